// File: doc/BRIEF.md
# Programmable Logic Cell with Split Lookup Table and Carry

This block is one configurable logic element of the kind repeated across a programmable fabric. A truth table of sixteen bits is held as two halves of eight bits, each addressed by the three low logic inputs. In logic mode the fourth input picks between the two halves, so the cell computes any function of four inputs. In arithmetic mode the two half results and a carry-in go to a full adder instead. The cell output is the sum, and the adder's carry-out passes to the next cell of a carry chain.

The cell output comes either straight from that logic or from a D flip-flop, which has a clock enable and a synchronous reset. The choice is set by configuration. All eighteen configuration bits sit in a shift chain. The chain is loaded one bit per enabled clock while configuration is enabled, and its last stage drives a serial output, so many cells can share one chain. The logic and carry pins are plain combinational signals with no handshake: every input is sampled or evaluated on each cycle.

Top module: `lcell_top`

## Requirements
- R1: While `cfg_en` and `cfg_shift` are both high at a rising edge, `cfg_din` enters the top of the 18-bit chain and every bit moves one place down. After 18 such shifts the first bit sent sits at bit 0. The chain layout is: bits [7:0] hold the low half table, bits [15:8] the high half table, bit 16 the mode (0 = logic, 1 = arithmetic) and bit 17 the output select (0 = combinational, 1 = registered).
- R2: `cfg_dout` always shows bit 0 of the chain. After a full load it equals the first bit sent, and after one more shift it equals the second bit sent.
- R3: Each half table is read at index {lin[2],lin[1],lin[0]}. In logic mode the combinational result is the high half's bit when lin[3] is 1 and the low half's bit when lin[3] is 0.
- R4: In arithmetic mode the combinational result is the XOR of the low half bit, the high half bit and `cin`. lin[3] has no effect in this mode.
- R5: In arithmetic mode `cout` is the majority of the low half bit, the high half bit and `cin`. In logic mode `cout` is 0.
- R6: With output select 1, `cell_out` shows the combinational result captured at the most recent rising edge that had `ce` high.
- R7: With `ce` low, the flip-flop keeps its value at a rising edge even when the inputs change.
- R8: `rst` high at a rising edge clears the flip-flop to 0, even when `ce` is high at that edge.
- R9: While `cfg_en` is high, `cell_out` and `cout` are 0 and the flip-flop holds its value even when `ce` is high. When `cfg_en` falls, the held value appears again.
- R10: A rising edge with `cfg_shift` high but `cfg_en` low leaves the chain unchanged. `cfg_dout` and the cell's function stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flip-flop and the configuration chain |
| rst | input | 1 | Synchronous active-high reset of the flip-flop |
| ce | input | 1 | Clock enable of the flip-flop |
| cfg_en | input | 1 | Configuration enable; blocks the cell while high |
| cfg_shift | input | 1 | Shift strobe for the configuration chain |
| cfg_din | input | 1 | Serial configuration input |
| cfg_dout | output | 1 | Serial configuration output (bit 0 of the chain) |
| lin | input | 4 | Logic inputs; [2:0] address the tables, [3] picks the half |
| cin | input | 1 | Carry from the previous cell |
| cout | output | 1 | Carry to the next cell |
| cell_out | output | 1 | Cell result, registered or combinational |

## Verification
Two functions can act in the same cycle: a configuration access and a flip-flop capture, because `ce` stays high while `cfg_en` is asserted. The bench first loads a one into the flip-flop. It then holds `ce` high through several configuration cycles and changes the inputs so that a capture would store a zero. It judges the result by checking that `cell_out` and `cout` read 0 during those cycles and that the stored one comes back once `cfg_en` drops. A second overlap is `rst` and `ce` high at the same edge: reset must win, and the bench checks this against a flip-flop that held a one.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  typedef enum logic {
    MODE_LOGIC = 1'b0,
    MODE_ARITH = 1'b1
  } cell_mode_e;

  typedef enum logic {
    OUT_COMB = 1'b0,
    OUT_REG  = 1'b1
  } out_sel_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_shift,
  input  logic         cfg_din,
  output logic [W-1:0] cfg_q,
  output logic         cfg_dout
);
  logic step;
  assign step = cfg_en & cfg_shift;

  always_ff @(posedge clk) begin
    if (step) cfg_q <= {cfg_din, cfg_q[W-1:1]};
  end

  assign cfg_dout = cfg_q[0];

  // R1: the new bit lands at the top of the chain
  a_r1_shift_in: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && cfg_shift) |=> (cfg_q[W-1] == $past(cfg_din)));

  // R10: no shift without both enables
  a_r10_chain_hold: assert property (@(posedge clk) disable iff (rst)
    !(cfg_en && cfg_shift) |=> $stable(cfg_q));
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int K = 3,
  localparam int N = 1 << K
) (
  input  logic [N-1:0] tbl,
  input  logic [K-1:0] idx,
  output logic         y
);
  assign y = tbl[idx];
endmodule

// File: rtl/lcell_arith.sv
module lcell_arith
  import lcell_pkg::*;
(
  input  cell_mode_e mode,
  input  logic       f_lo,
  input  logic       f_hi,
  input  logic       pick_hi,
  input  logic       cin,
  output logic       y,
  output logic       cout_raw
);
  logic sum;
  logic wide;

  assign wide = pick_hi ? f_hi : f_lo;
  assign sum  = f_lo ^ f_hi ^ cin;

  always_comb begin
    if (mode == MODE_ARITH) begin
      y        = sum;
      cout_raw = maj3(f_lo, f_hi, cin);
    end else begin
      y        = wide;
      cout_raw = 1'b0;
    end
  end
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
#(
  parameter int LUT_K = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic           cfg_en,
  input  logic           cfg_shift,
  input  logic           cfg_din,
  output logic           cfg_dout,
  input  logic [LUT_K:0] lin,
  input  logic           cin,
  output logic           cout,
  output logic           cell_out
);
  localparam int TBL   = 1 << LUT_K;
  localparam int CFG_W = 2 * TBL + 2;
  localparam int MODE_BIT = 2 * TBL;
  localparam int OSEL_BIT = 2 * TBL + 1;

  logic [CFG_W-1:0] cfg_q;
  logic [1:0]       half_y;
  logic             comb_y;
  logic             cout_raw;
  logic             ff_q;
  cell_mode_e       mode;
  out_sel_e         osel;

  lcell_cfg_chain #(.W(CFG_W)) chain_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_shift(cfg_shift),
    .cfg_din(cfg_din), .cfg_q(cfg_q), .cfg_dout(cfg_dout)
  );

  assign mode = cell_mode_e'(cfg_q[MODE_BIT]);
  assign osel = out_sel_e'(cfg_q[OSEL_BIT]);

  for (genvar h = 0; h < 2; h++) begin : g_half
    lcell_lut #(.K(LUT_K)) lut_i (
      .tbl(cfg_q[h*TBL +: TBL]),
      .idx(lin[LUT_K-1:0]),
      .y(half_y[h])
    );
  end

  lcell_arith arith_i (
    .mode(mode), .f_lo(half_y[0]), .f_hi(half_y[1]), .pick_hi(lin[LUT_K]),
    .cin(cin), .y(comb_y), .cout_raw(cout_raw)
  );

  always_ff @(posedge clk) begin
    if (rst)               ff_q <= 1'b0;
    else if (ce && !cfg_en) ff_q <= comb_y;
  end

  always_comb begin
    if (cfg_en)              cell_out = 1'b0;
    else if (osel == OUT_REG) cell_out = ff_q;
    else                     cell_out = comb_y;
  end

  assign cout = cfg_en ? 1'b0 : cout_raw;

  // R5: logic mode never drives a carry
  a_r5_cout_logic: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LOGIC) |-> !cout);

  // R9: configuration blanks the outputs and freezes the flop
  a_r9_blank: assert property (@(posedge clk) disable iff (rst)
    cfg_en |-> (!cell_out && !cout));
  a_r9_ff_hold: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> $stable(ff_q));

  // R6: an enabled edge captures the combinational result
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    (ce && !cfg_en) |=> (ff_q == $past(comb_y)));

  // R7: a disabled edge keeps the flop
  a_r7_ce_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(ff_q));

  // R8: reset clears the flop
  a_r8_reset: assert property (@(posedge clk) rst |=> !ff_q);
endmodule

// File: tb/lcell_top_tb.sv
module lcell_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, ce, cfg_en, cfg_shift, cfg_din, cin;
  logic [3:0] lin;
  logic       cfg_dout, cout, cell_out;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcell_top dut_i (
    .clk(clk), .rst(rst), .ce(ce), .cfg_en(cfg_en), .cfg_shift(cfg_shift),
    .cfg_din(cfg_din), .cfg_dout(cfg_dout), .lin(lin), .cin(cin),
    .cout(cout), .cell_out(cell_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [17:0] w);
    for (int i = 0; i < 18; i++) begin
      @(negedge clk);
      cfg_en = 1'b1; cfg_shift = 1'b1; cfg_din = w[i];
    end
    @(negedge clk);
    cfg_en = 1'b0; cfg_shift = 1'b0; cfg_din = 1'b0;
  endtask

  function automatic logic [1:0] model(input logic [7:0] lo, input logic [7:0] hi,
                                       input logic ar, input logic [3:0] x, input logic c);
    logic a, b;
    a = lo[x[2:0]];
    b = hi[x[2:0]];
    if (ar) return {(a & b) | (a & c) | (b & c), a ^ b ^ c};
    return {1'b0, x[3] ? b : a};
  endfunction

  task automatic sweep_comb(input logic [7:0] lo, input logic [7:0] hi, input logic ar,
                            input string req);
    logic [1:0] e;
    for (int x = 0; x < 16; x++) begin
      for (int c = 0; c < 2; c++) begin
        @(negedge clk);
        lin = 4'(x); cin = 1'(c);
        #1;
        e = model(lo, hi, ar, 4'(x), 1'(c));
        chk(req, int'(cell_out), int'(e[0]));
        chk(ar ? "R5 carry arith" : "R5 carry zero", int'(cout), int'(e[1]));
      end
    end
  endtask

  initial begin
    logic [7:0] los [4];
    logic [7:0] his [4];
    logic [1:0] e;
    los = '{8'h96, 8'hF0, 8'h01, 8'hA5};
    his = '{8'h6A, 8'h0F, 8'h80, 8'h3C};
    rst = 1'b1; ce = 1'b0; cfg_en = 1'b0; cfg_shift = 1'b0; cfg_din = 1'b0;
    cin = 1'b0; lin = 4'h0;
    load_cfg(18'h00000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R8 reset out", int'(cell_out), 0);
    chk("R8 reset cout", int'(cout), 0);

    for (int t = 0; t < 4; t++) begin
      // R1 R3: logic mode, combinational
      load_cfg({1'b0, 1'b0, his[t], los[t]});
      sweep_comb(los[t], his[t], 1'b0, "R3 logic mode");
      // R1 R4: arithmetic mode, combinational
      load_cfg({1'b0, 1'b1, his[t], los[t]});
      sweep_comb(los[t], his[t], 1'b1, "R4 arith sum");
    end

    // R2: serial output
    load_cfg(18'h2_5A96);
    chk("R2 dout first", int'(cfg_dout), 0);
    @(negedge clk); cfg_en = 1'b1; cfg_shift = 1'b1; cfg_din = 1'b0;
    @(negedge clk); cfg_en = 1'b0; cfg_shift = 1'b0;
    #1;
    chk("R2 dout second", int'(cfg_dout), 1);

    // R6: registered output in logic mode
    load_cfg({1'b1, 1'b0, 8'h3C, 8'hC5});
    ce = 1'b1;
    for (int x = 0; x < 16; x++) begin
      @(negedge clk); lin = 4'(x);
      @(posedge clk); #1;
      e = model(8'hC5, 8'h3C, 1'b0, 4'(x), 1'b0);
      chk("R6 registered", int'(cell_out), int'(e[0]));
    end
    // R6: registered output in arithmetic mode
    load_cfg({1'b1, 1'b1, 8'h3C, 8'hC5});
    for (int x = 0; x < 8; x++) begin
      for (int c = 0; c < 2; c++) begin
        @(negedge clk); lin = 4'(x); cin = 1'(c);
        @(posedge clk); #1;
        e = model(8'hC5, 8'h3C, 1'b1, 4'(x), 1'(c));
        chk("R6 registered arith", int'(cell_out), int'(e[0]));
      end
    end

    // R7: ce low holds; low table FF, high 00, logic mode, registered
    load_cfg({1'b1, 1'b0, 8'h00, 8'hFF});
    @(negedge clk); ce = 1'b1; lin = 4'h0;
    @(negedge clk); ce = 1'b0; lin = 4'h8;
    @(posedge clk); #1;
    chk("R7 ce hold one", int'(cell_out), 1);
    @(negedge clk); ce = 1'b1;
    @(posedge clk); #1;
    chk("R7 ce reenable", int'(cell_out), 0);
    @(negedge clk); ce = 1'b0; lin = 4'h0;
    @(posedge clk); #1;
    chk("R7 ce hold zero", int'(cell_out), 0);

    // R8: reset beats ce
    @(negedge clk); ce = 1'b1; lin = 4'h0;
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R8 reset over ce", int'(cell_out), 0);
    @(negedge clk); rst = 1'b0;

    // R9: configuration overlaps capture
    @(negedge clk); ce = 1'b1; lin = 4'h0;
    @(posedge clk); #1;
    chk("R9 preload one", int'(cell_out), 1);
    @(negedge clk); cfg_en = 1'b1; cfg_shift = 1'b0; lin = 4'h8;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R9 out blanked", int'(cell_out), 0);
    end
    @(negedge clk); cfg_en = 1'b0; ce = 1'b0;
    #1;
    chk("R9 held value back", int'(cell_out), 1);
    load_cfg({1'b0, 1'b1, 8'hFF, 8'hFF});
    @(negedge clk); cin = 1'b1; lin = 4'h0;
    #1;
    chk("R5 carry before blank", int'(cout), 1);
    @(negedge clk); cfg_en = 1'b1;
    #1;
    chk("R9 cout blanked", int'(cout), 0);
    chk("R9 sum blanked", int'(cell_out), 0);
    @(negedge clk); cfg_en = 1'b0;

    // R10: shift strobe without enable is ignored
    load_cfg({1'b0, 1'b0, 8'h6A, 8'h96});
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); cfg_shift = 1'b1; cfg_din = 1'(i);
    end
    @(negedge clk); cfg_shift = 1'b0;
    #1;
    chk("R10 dout unchanged", int'(cfg_dout), 0);
    sweep_comb(8'h96, 8'h6A, 1'b0, "R10 function unchanged");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule